// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets synchronous logic talk to an external asynchronous static RAM of 2^18 bytes. The RAM has an active-low select, an active-high select, an active-low write strobe and an active-low output enable. The user side accepts a single request when `req_ready` is high. A request carries a write flag, an address and write data. A read returns its byte with a one-cycle `rsp_valid` pulse.

Every phase of a memory cycle is timed by a loadable down-counter. Each counter length is derived at elaboration from the memory's nanosecond minimums and the clock period parameter, rounding up. The bus data lines are split into an output value, an output-enable and an input value, so a pad-level tristate buffer can be built from them. The controller turns its driver on only for writes and never while the RAM's output enable is active.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the cycle after it is released, the outputs show standby: `req_ready`=1, `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: The RAM counts as selected only when `mem_cs_n`=0 and `mem_cs`=1. Both selects are active during every read and write cycle. Both are inactive whenever the controller is idle.
- R3: A write stores `req_wdata` at `req_addr`. A later read of that address returns the same byte.
- R4: `mem_we_n` stays low for exactly WP cycles. WP is the largest of ceil(t/CLK_NS) over the write pulse (75 ns), data-valid-before-end (45 ns), select-before-end (80 ns) and address-before-end (80 ns) minimums.
- R5: Address, both selects and write data are valid with the driver on in the cycle before `mem_we_n` falls. They stay unchanged while it is low and for at least one cycle after it rises.
- R6: `mem_oe_n` stays high throughout a write cycle. `mem_dq_oe` is high only during write cycles.
- R7: `mem_dq_oe` is low in the cycle before `mem_oe_n` falls, including when a read directly follows a write.
- R8: A read holds select, `mem_we_n`=1 and `mem_oe_n`=0 for RD cycles. RD = max of ceil(100 ns/CLK_NS) and ceil(50 ns/CLK_NS). The byte on `mem_dq_in` is captured at the end of the last of these cycles. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R9: `req_ready` is low for the whole memory cycle. A request raised while `req_ready` is low is not taken and writes nothing.
- R10: A write keeps `req_ready` low for 1+WP+HOLD cycles, where HOLD = max(1, ceil(100 ns/CLK_NS)-1-WP). A read keeps it low for RD cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable of the controller's data driver |
| mem_dq_in | input | DATA_W | Data read from the RAM pins |

## Verification
The bench builds the controller with a 4-bit address and an 8 ns clock period. This makes WP 10, HOLD 2 and RD 13 cycles, and it makes every address reachable. Two complete write/read sweeps visit all 16 words with data computed from the address.

A bench memory model commits a byte only when the write strobe ends and records how long the strobe was low. It returns inverted data until the address and output enable have been stable for RD cycles, so a capture even one cycle early produces wrong data. Read-after-write pairs on the same word exercise bus turnaround. A request held during a busy cycle exercises request rejection.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS
  } ctl_state_e;

  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles the write strobe is held low
  function automatic int wr_pulse_cyc(input int clk_ns, input int t_wp,
                                      input int t_dw, input int t_cw,
                                      input int t_aw);
    return imax(imax(ns_to_cyc(t_wp, clk_ns), ns_to_cyc(t_dw, clk_ns)),
                imax(ns_to_cyc(t_cw, clk_ns), ns_to_cyc(t_aw, clk_ns)));
  endfunction

  // cycles after the strobe rises, padding the whole write to its minimum
  function automatic int wr_hold_cyc(input int clk_ns, input int t_wc,
                                     input int wp);
    return imax(1, ns_to_cyc(t_wc, clk_ns) - 1 - wp);
  endfunction

  // cycles output enable and address are held before capture
  function automatic int rd_access_cyc(input int clk_ns, input int t_rc,
                                       input int t_aa, input int t_oe);
    return imax(ns_to_cyc(t_rc, clk_ns),
                imax(ns_to_cyc(t_aa, clk_ns), ns_to_cyc(t_oe, clk_ns)));
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int WP_CYC   = 8,
  parameter int HOLD_CYC = 1,
  parameter int RD_CYC   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output ctl_state_e       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_RACCESS;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          state_d  = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WHOLD: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      ST_RACCESS: begin
        if (tmr_expired) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              busy;
  logic              in_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= mem_dq_in;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign in_write = (state == ST_WSETUP) || (state == ST_WPULSE) ||
                    (state == ST_WHOLD);

  assign req_ready  = !busy;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_cs_n   = !busy;
  assign mem_cs     = busy;
  assign mem_we_n   = (state != ST_WPULSE);
  assign mem_oe_n   = (state != ST_RACCESS);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = in_write;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 100,
  parameter int T_AA_NS = 100,
  parameter int T_OE_NS = 50,
  parameter int T_WC_NS = 100,
  parameter int T_WP_NS = 75,
  parameter int T_DW_NS = 45,
  parameter int T_CW_NS = 80,
  parameter int T_AW_NS = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int WP_CYC   = wr_pulse_cyc(CLK_NS, T_WP_NS, T_DW_NS, T_CW_NS, T_AW_NS);
  localparam int HOLD_CYC = wr_hold_cyc(CLK_NS, T_WC_NS, WP_CYC);
  localparam int RD_CYC   = rd_access_cyc(CLK_NS, T_RC_NS, T_AA_NS, T_OE_NS);
  localparam int MAX_CYC  = imax(WP_CYC, imax(HOLD_CYC, RD_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctl_state_e       state;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             req_accept;   // request taken this cycle
  logic             rd_capture;   // read byte sampled at this edge

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctl_seq #(
    .CNT_W    (CNT_W),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RD_CYC   (RD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .state       (state),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (req_accept),
    .capture     (rd_capture)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .accept     (req_accept),
    .capture    (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int WP_CYC = 8,
  parameter int RD_CYC = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rd_capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [31:0] we_lo_cnt;
  logic [31:0] oe_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= mem_we_n ? 32'd0 : we_lo_cnt + 32'd1;
      oe_lo_cnt <= mem_oe_n ? 32'd0 : oe_lo_cnt + 32'd1;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && !mem_dq_oe)); // R2
  AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs)); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 32'(WP_CYC))); // R4
  AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $past(!mem_cs_n) && $stable(mem_addr))); // R5
  AST_WRITE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R5
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs_n && mem_cs && $stable(mem_addr) && $stable(mem_dq_out))); // R5
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R6
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R7
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt == 32'(RD_CYC))); // R8
  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_oe_n && mem_we_n && !mem_cs_n)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n || mem_dq_oe) |-> !req_ready); // R9
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC),
  .RD_CYC (RD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rd_capture (rd_capture),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_cs     (mem_cs),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CK = 8;

  // smallest n with n*CK >= t
  function automatic int cyc_of(input int t);
    int n = 0;
    while (n * CK < t) n++;
    return n;
  endfunction

  localparam int WP_E   = cyc_of(80);                 // 75,45,80,80 -> 80 ns dominates
  localparam int WC_E   = cyc_of(100);
  localparam int HOLD_E = (WC_E - 1 - WP_E < 1) ? 1 : WC_E - 1 - WP_E;
  localparam int RD_E   = cyc_of(100);                // 100 ns beats 50 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int checks = 0, failures = 0, cycles = 0;

  always #4 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CK)) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- RAM model, sampled at falling edges ----------------
  logic [DW-1:0] mdl [1<<AW];
  int we_lo = 0, rd_stable = 0;
  logic [AW-1:0] wr_a, last_a;
  logic [DW-1:0] wr_d;
  logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_sel = 1'b0;
  logic [AW-1:0] prev_a = '0;
  wire selected = !mem_cs_n && mem_cs;

  assign mem_dq_in = (rd_stable >= RD_E) ? mdl[mem_addr] : ~mdl[mem_addr];

  initial for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n && mem_dq_oe) check(0, "R6 contention", 1, 0);
      if (!mem_oe_n && prev_oe_n) check(!prev_dq_oe, "R7 driver off before oe", prev_dq_oe, 0);
      if (selected && !mem_we_n) begin
        if (prev_we_n) begin
          check(prev_dq_oe && prev_sel && prev_a == mem_addr, "R5 setup", prev_dq_oe, 1);
          we_lo = 0;
        end else if (mem_addr != wr_a || mem_dq_out != wr_d) begin
          check(0, "R5 steady", int'(mem_addr), int'(wr_a));
        end
        we_lo++;
        wr_a = mem_addr;
        wr_d = mem_dq_out;
      end
      if (mem_we_n && !prev_we_n) begin
        check(we_lo == WP_E, "R4 pulse width", we_lo, WP_E);
        check(mem_dq_oe && selected && mem_addr == wr_a && mem_dq_out == wr_d,
              "R5 hold", mem_dq_oe, 1);
        mdl[wr_a] = wr_d;
      end
      if (selected && !mem_oe_n && mem_we_n)
        rd_stable = (!prev_oe_n && mem_addr == last_a) ? rd_stable + 1 : 1;
      else
        rd_stable = 0;
      last_a = mem_addr;
    end
    prev_we_n  = mem_we_n;
    prev_oe_n  = mem_oe_n;
    prev_dq_oe = mem_dq_oe;
    prev_sel   = selected;
    prev_a     = mem_addr;
  end

  // ---------------- request helper ----------------
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output int busy, output bit vld);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      if (rsp_valid) check(0, "R9 valid while busy", 1, 0);
      if (wr && !mem_oe_n) check(0, "R6 oe low in write", 0, 1);
      if (!wr && mem_dq_oe) check(0, "R6 driver on in read", 1, 0);
      if (!(mem_cs && !mem_cs_n)) check(0, "R2 not selected in cycle", 0, 1);
      busy++;
      @(negedge clk);
    end
    rd  = rsp_rdata;
    vld = rsp_valid;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return DW'((a * 37 + 5 + pass * 91) & 8'hFF);
  endfunction

  logic [DW-1:0] rd;
  int busy;
  bit vld;

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R1 reset state", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R1 after release", req_ready, 1);

    // pass 0: write every word, then read every word
    for (int a = 0; a < (1 << AW); a++) begin
      do_op(1'b1, AW'(a), pat(a, 0), rd, busy, vld);
      check(busy == 1 + WP_E + HOLD_E, "R10 write busy", busy, 1 + WP_E + HOLD_E);
      check(!vld, "R8 no response to write", vld, 0);
      check(mem_cs_n && !mem_cs, "R2 standby after write", mem_cs, 0);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      do_op(1'b0, AW'(a), '0, rd, busy, vld);
      check(busy == RD_E, "R10 read busy", busy, RD_E);
      check(vld, "R8 valid pulse", vld, 1);
      check(rd == pat(a, 0), "R3 read back", rd, pat(a, 0));
      @(negedge clk);
      check(!rsp_valid, "R8 valid one cycle", rsp_valid, 0);
    end

    // pass 1: write then immediate read of the same word (turnaround)
    for (int a = (1 << AW) - 1; a >= 0; a--) begin
      do_op(1'b1, AW'(a), pat(a, 1), rd, busy, vld);
      do_op(1'b0, AW'(a), '0, rd, busy, vld);
      check(vld && rd == pat(a, 1), "R3 R7 write-read pair", rd, pat(a, 1));
    end

    // request held while busy must be ignored
    do_op(1'b1, 4'd3, 8'h5A, rd, busy, vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd7; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 4'd9; req_wdata = 8'hEE; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    check(!req_ready, "R9 ready low in cycle", req_ready, 0);
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    do_op(1'b0, 4'd9, '0, rd, busy, vld);
    check(rd == pat(9, 1), "R9 busy request ignored", rd, pat(9, 1));
    do_op(1'b0, 4'd7, '0, rd, busy, vld);
    check(rd == 8'h11, "R3 accepted write", rd, 8'h11);
    do_op(1'b0, 4'd3, '0, rd, busy, vld);
    check(rd == 8'h5A, "R3 earlier write", rd, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule